// File: doc/BRIEF.md
# Sleep-Aware Sticky Error Status Register

This block keeps an 8-bit latched record of error events for a hardware monitor. Five sources feed it: four temperature-zone out-of-limit flags and a voltage-regulator-hot input. When a source reports an error and is not masked, its status bit sets and stays set after the source goes quiet. Software sees the bits through a small register port with an address, a read strobe, a write strobe, write data and read data, and clears them by writing ones.

A 2-bit sleep-state register holds the system power state. Two 5-bit mask registers, one for S3 and one for S4/S5, choose which sources are ignored in each of those states. A source that is not masked and is still reporting an error cannot be cleared. A masked source does not set its bit, and its bit can be cleared even while the source is still active. A mode input adds read-to-clear on top of write-one-to-clear.

Top module: `sticky_err_status`

## Requirements
- R1: Status bit 0 records zone 1, bit 1 zone 2, bit 2 zone 3, bit 3 zone 4 and bit 4 the regulator-hot input. The status register is at address 0.
- R2: Status bits 7:5 always read as 0, and write data in bits 7:5 has no effect.
- R3: After reset the status, sleep-state and both mask registers read 00h.
- R4: A source that is high and unmasked at a clock edge sets its status bit at that edge. The bit stays set after the source drops, until software clears it.
- R5: Writing address 0 clears every status bit whose write-data bit is 1 and whose source is inactive or masked. Bits written with 0 keep their value.
- R6: A clear, whether by write or by read, is refused for a bit whose source is high and unmasked in that cycle. Such a bit stays set.
- R7: A masked source does not set its bit, and a clear of its bit succeeds even while the source is high.
- R8: The sleep-state register is at address 1, bits 1:0. Value 0 (S0) masks nothing. Value 1 (S3) masks the sources whose bits are set in the S3 mask at address 2, bits 4:0. Values 2 and 3 (S4/S5) use the S4/S5 mask at address 3, bits 4:0. Masking follows the register value held before the edge.
- R9: With clrOnRead high, a read strobe at address 0 returns the status and clears the returned bits at that edge, subject to R6. With clrOnRead low, a read leaves the status unchanged.
- R10: rdData shows the addressed register combinationally: {6'b0, state} at address 1 and {3'b0, mask} at addresses 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| errIn | input | 5 | Error sources: zones 1 to 4, then regulator-hot |
| clrOnRead | input | 1 | Mode: reads of status also clear |
| addr | input | 2 | Register address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the addressed register |

## Verification
A wrong status bit shows on rdData at address 0 in the cycle right after the edge that corrupted it. A wrong sleep-state or mask value shows up in one of two ways: by direct readback, or as a bit that sets or clears when it should not one edge later. The bench keeps address 0 on the bus for most cycles and compares every cycle, so a mistake in set, clear or masking is caught within one clock.

// File: rtl/sesr_pkg.sv
package sesr_pkg;
  localparam int NUM_SRC = 5;

  typedef enum logic [1:0] {
    SLP_AWAKE = 2'd0,
    SLP_S3    = 2'd1,
    SLP_S45   = 2'd2,
    SLP_S45B  = 2'd3
  } sleepState_t;

  typedef struct packed {
    logic [NUM_SRC-1:0] wrClr;
    logic               rdClr;
  } clrStrobes_t;
endpackage

// File: rtl/sesr_ctrl.sv
module sesr_ctrl
  import sesr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               clrOnRead,
  input  logic [NUM_SRC-1:0] statusQ,
  output clrStrobes_t        strb,
  output logic [NUM_SRC-1:0] maskVec,
  output logic [DATA_W-1:0]  rdData
);
  localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_SLEEP  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_MSK_S3 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADR_MSK_S45 = ADDR_W'(3);
  localparam int PAD_W = DATA_W - NUM_SRC;

  sleepState_t        sleepQ;
  logic [NUM_SRC-1:0] mskS3Q;
  logic [NUM_SRC-1:0] mskS45Q;
  logic               unusedHiBits;

  assign unusedHiBits = ^wrData[DATA_W-1:NUM_SRC];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepQ  <= SLP_AWAKE;
      mskS3Q  <= '0;
      mskS45Q <= '0;
    end else if (wrEn) begin
      case (addr)
        ADR_SLEEP:   sleepQ  <= sleepState_t'(wrData[1:0]);
        ADR_MSK_S3:  mskS3Q  <= wrData[NUM_SRC-1:0];
        ADR_MSK_S45: mskS45Q <= wrData[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sleepQ)
      SLP_S3:            maskVec = mskS3Q;
      SLP_S45, SLP_S45B: maskVec = mskS45Q;
      default:           maskVec = '0;
    endcase
  end

  always_comb begin
    strb.wrClr = (wrEn && addr == ADR_STATUS) ? wrData[NUM_SRC-1:0] : '0;
    strb.rdClr = rdEn && clrOnRead && (addr == ADR_STATUS);
  end

  always_comb begin
    case (addr)
      ADR_STATUS:  rdData = {{PAD_W{1'b0}}, statusQ};
      ADR_SLEEP:   rdData = {{(DATA_W-2){1'b0}}, sleepQ};
      ADR_MSK_S3:  rdData = {{PAD_W{1'b0}}, mskS3Q};
      default:     rdData = {{PAD_W{1'b0}}, mskS45Q};
    endcase
  end
endmodule

// File: rtl/sesr_datapath.sv
module sesr_datapath
  import sesr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] errIn,
  input  logic [NUM_SRC-1:0] maskVec,
  input  clrStrobes_t        strb,
  output logic [NUM_SRC-1:0] statusQ
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic liveErr;
    logic clrReq;
    assign liveErr = errIn[i] & ~maskVec[i];
    assign clrReq  = strb.wrClr[i] | (strb.rdClr & statusQ[i]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        statusQ[i] <= 1'b0;
      else if (liveErr) statusQ[i] <= 1'b1;
      else if (clrReq)  statusQ[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sticky_err_status.sv
module sticky_err_status
  import sesr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] errIn,
  input  logic               clrOnRead,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData
);
  clrStrobes_t        strb;
  logic [NUM_SRC-1:0] maskVec;
  logic [NUM_SRC-1:0] statusQ;

  sesr_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .clrOnRead(clrOnRead), .statusQ(statusQ),
    .strb(strb), .maskVec(maskVec), .rdData(rdData)
  );

  sesr_datapath u_dp (
    .clk(clk), .rstN(rstN), .errIn(errIn), .maskVec(maskVec),
    .strb(strb), .statusQ(statusQ)
  );
endmodule

// File: rtl/sticky_err_status_chk.sv
module sticky_err_status_chk
  import sesr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] errIn,
  input logic [NUM_SRC-1:0] maskVec,
  input logic [NUM_SRC-1:0] statusQ,
  input logic               clrOnRead,
  input logic [ADDR_W-1:0]  addr,
  input logic               rdEn,
  input logic               wrEn,
  input logic [DATA_W-1:0]  rdData
);
  logic statusAccess;
  assign statusAccess = (addr == '0);

  // R2: reserved bits of the status register read 0
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusAccess |-> (rdData[DATA_W-1:NUM_SRC] == '0));

  // R4: live unmasked error is recorded at the edge
  assert_live_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|(errIn & ~maskVec)) |=> ((statusQ & $past(errIn & ~maskVec)) == $past(errIn & ~maskVec)));

  // R4: with no clear strobe, set bits never fall
  assert_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(statusAccess && (wrEn || (rdEn && clrOnRead))) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  // R7: a bit can only rise from a live unmasked source
  assert_masked_no_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ~$past(statusQ) & ~$past(errIn & ~maskVec)) == '0));

  // R9: read without clear mode leaves status unchanged
  assert_plain_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !clrOnRead && !wrEn) |=> ((statusQ & $past(statusQ)) == $past(statusQ)));
endmodule

bind sticky_err_status sticky_err_status_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .errIn(errIn), .maskVec(maskVec), .statusQ(statusQ),
  .clrOnRead(clrOnRead), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .rdData(rdData)
);

// File: tb/sticky_err_status_tb.sv
module sticky_err_status_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] errIn = '0;
  logic       clrOnRead = 1'b0;
  logic [1:0] addr = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;

  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  logic [4:0] mStat = '0;
  logic [1:0] mSlp = '0;
  logic [4:0] mS3 = '0;
  logic [4:0] mS45 = '0;

  always #5 clk = ~clk;

  sticky_err_status u_dut (
    .clk(clk), .rstN(rstN), .errIn(errIn), .clrOnRead(clrOnRead),
    .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0:    return {3'b0, mStat};
      2'd1:    return {6'b0, mSlp};
      2'd2:    return {3'b0, mS3};
      default: return {3'b0, mS45};
    endcase
  endfunction

  task automatic step(input string tag, input logic [4:0] e, input logic [1:0] a,
                      input logic rd, input logic wr, input logic [7:0] wd, input logic cor);
    logic [4:0] msk;
    logic [4:0] clr;
    @(negedge clk);
    errIn = e; addr = a; rdEn = rd; wrEn = wr; wrData = wd; clrOnRead = cor;
    #1;
    nVec++;
    if (rdData !== expRead(a)) begin
      nBad++;
      $display("FAIL %s addr=%0d actual=%02h expected=%02h", tag, a, rdData, expRead(a));
    end
    @(posedge clk);
    msk = (mSlp == 2'd1) ? mS3 : (mSlp >= 2'd2) ? mS45 : 5'b0;
    clr = ((wr && a == 2'd0) ? wd[4:0] : 5'b0) | ((rd && cor && a == 2'd0) ? mStat : 5'b0);
    mStat = (e & ~msk) | (mStat & ~clr);
    if (wr && a == 2'd1) mSlp = wd[1:0];
    if (wr && a == 2'd2) mS3 = wd[4:0];
    if (wr && a == 2'd3) mS45 = wd[4:0];
  endtask

  task automatic idle(input string tag, input int n);
    for (int k = 0; k < n; k++) step(tag, errIn, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R3: reset values of all registers
    for (int a = 0; a < 4; a++) step("R3", 5'h00, 2'(a), 1'b0, 1'b0, 8'h00, 1'b0);
    // R1/R4: each source sets its own bit and holds after dropping
    for (int b = 0; b < 5; b++) begin
      step("R1", 5'(1 << b), 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
      step("R4", 5'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
      step("R4", 5'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
      step("R5", 5'h00, 2'd0, 1'b0, 1'b1, 8'h1F, 1'b0);
    end
    // R2: reserved write ignored, reads 0
    step("R4", 5'h1F, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R2", 5'h00, 2'd0, 1'b0, 1'b1, 8'hE0, 1'b0);
    step("R2", 5'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    // R5: zeros keep bits, ones clear
    step("R5", 5'h00, 2'd0, 1'b0, 1'b1, 8'h0A, 1'b0);
    step("R5", 5'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    // R6: clear refused while live
    step("R6", 5'h04, 2'd0, 1'b0, 1'b1, 8'h1F, 1'b0);
    step("R6", 5'h04, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R6", 5'h00, 2'd0, 1'b0, 1'b1, 8'h04, 1'b0);
    step("R5", 5'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    // R10/R8: configure S3 masking of zones 1 and 2
    step("R10", 5'h00, 2'd2, 1'b0, 1'b1, 8'hE3, 1'b0);
    step("R10", 5'h00, 2'd2, 1'b1, 1'b0, 8'h00, 1'b0);
    step("R10", 5'h00, 2'd3, 1'b0, 1'b1, 8'hF8, 1'b0);
    step("R10", 5'h00, 2'd3, 1'b1, 1'b0, 8'h00, 1'b0);
    // in S0 zone 1 still sets
    step("R8", 5'h01, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R8", 5'h00, 2'd1, 1'b0, 1'b1, 8'h01, 1'b0);
    step("R10", 5'h00, 2'd1, 1'b0, 1'b0, 8'h00, 1'b0);
    // R7: masked zone 1 clears while active; masked zone 2 does not set; zone 3 sets
    step("R7", 5'h07, 2'd0, 1'b0, 1'b1, 8'h01, 1'b0);
    step("R7", 5'h07, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R7", 5'h00, 2'd0, 1'b0, 1'b1, 8'h1F, 1'b0);
    // R8: S4/S5 uses its own mask (zones 4 and VR-hot), state 2 and 3
    step("R8", 5'h00, 2'd1, 1'b0, 1'b1, 8'h02, 1'b0);
    step("R8", 5'h1F, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R8", 5'h00, 2'd0, 1'b0, 1'b1, 8'h1F, 1'b0);
    step("R8", 5'h00, 2'd1, 1'b0, 1'b1, 8'hFF, 1'b0);
    step("R8", 5'h1F, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R8", 5'h00, 2'd1, 1'b0, 1'b1, 8'h00, 1'b0);
    step("R8", 5'h00, 2'd0, 1'b0, 1'b1, 8'h1F, 1'b0);
    step("R8", 5'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    // R9: read-to-clear modes
    step("R4", 5'h15, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R9", 5'h00, 2'd0, 1'b1, 1'b0, 8'h00, 1'b0);
    step("R9", 5'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b0);
    step("R9", 5'h00, 2'd1, 1'b1, 1'b0, 8'h00, 1'b1);
    step("R9", 5'h10, 2'd0, 1'b1, 1'b0, 8'h00, 1'b1);
    step("R6", 5'h00, 2'd0, 1'b0, 1'b0, 8'h00, 1'b1);
    step("R9", 5'h00, 2'd0, 1'b1, 1'b0, 8'h00, 1'b1);
    idle("R9", 3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule